// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block is the transfer engine for a single DMA channel. Software loads a base address, a base transfer count and a page number. Each time the channel is granted the bus, the engine forms a 24-bit physical memory address from the page and the 16-bit current address. It then steps the current address and count. The channel is either byte wide or word wide. On a word channel the 16-bit counter is shifted up one bit and the low page bit is dropped, so a word channel covers a 128K region instead of a 64K one.

Transfers use a single-transfer handshake:

1. A request from a device raises a hold request.
2. The engine waits for the hold acknowledge.
3. It drives the device acknowledge, the address and the read/write strobes for exactly one cycle.

When the count runs out, the engine flags terminal count. It then either reloads from the base registers (autoinit) or masks itself. A cascade setting turns the channel into a plain wire path: request to hold request, and hold acknowledge to device acknowledge. This lets a second controller sit behind it.

Top module: `dma_chan_engine`

## Requirements
- R1: On a byte channel (`cfg_word`=0), `phys_addr` during an acknowledge cycle equals `{cfg_page[7:0], cur_addr[15:0]}`.
- R2: On a word channel (`cfg_word`=1), `phys_addr` during an acknowledge cycle equals `{cfg_page[7:1], cur_addr[15:0], 1'b0}`, and page bit 0 has no effect.
- R3: The current address wraps inside 16 bits (0xFFFF steps to 0x0000 when counting up, 0x0000 to 0xFFFF when counting down). The page part of `phys_addr` is never altered by a transfer.
- R4: A programmed count N yields N+1 transfers. `tc` is high only in the acknowledge cycle where the count is 0x0000, and without autoinit the count then reads 0xFFFF.
- R5: Each transfer moves `cur_addr` by one register unit: +1 when `cfg_dec`=0 and -1 when `cfg_dec`=1. `cur_count` decrements by one.
- R6: With `cfg_autoinit`=1, the terminal-count transfer reloads `cur_addr` and `cur_count` from the base values, and the mask is left unchanged.
- R7: With `cfg_autoinit`=0, the terminal-count transfer sets `chan_masked`. If a `mask_wr` lands in that same cycle, the written value wins.
- R8: Single handshake. An unmasked request seen while idle raises `hrq` on the next cycle. `hlda` seen while requesting gives `dack` for exactly one cycle on the following cycle. No new request starts until `dreq` has gone low.
- R9: While `chan_masked`=1, `dreq` is ignored and `hrq` stays low (non-cascade).
- R10: With `cfg_cascade`=1, `hrq` = `dreq & ~chan_masked` and `dack` = `hrq & hlda` in the same cycle. `tc` stays 0, and `cur_addr` and `cur_count` do not change.
- R11: During an acknowledge cycle, `mem_wr` is high when `cfg_to_mem`=1 (I/O to memory) and `mem_rd` is high when `cfg_to_mem`=0. Both are low otherwise.
- R12: A `prog_load` pulse copies `prog_base_addr` and `prog_base_cnt` into both the base and the current registers at the next edge, taking priority over a transfer step.
- R13: After reset the engine is idle, `hrq`, `dack` and `tc` are 0, `chan_masked` is 1, and `cur_addr` and `cur_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_word | input | 1 | 1 = word channel, 0 = byte channel |
| cfg_cascade | input | 1 | 1 = cascade pass-through |
| cfg_autoinit | input | 1 | Reload from base at terminal count |
| cfg_dec | input | 1 | 1 = address counts down |
| cfg_to_mem | input | 1 | 1 = I/O to memory, 0 = memory to I/O |
| cfg_page | input | 8 | Page number (upper address bits) |
| prog_load | input | 1 | Load base and current registers |
| prog_base_addr | input | 16 | Base address to load |
| prog_base_cnt | input | 16 | Base count (transfers minus one) to load |
| mask_wr | input | 1 | Write the mask bit |
| mask_val | input | 1 | Mask value to write |
| dreq | input | 1 | Device request |
| hlda | input | 1 | Hold acknowledge from bus owner |
| hrq | output | 1 | Hold request |
| dack | output | 1 | Device acknowledge |
| phys_addr | output | 24 | Physical memory address, valid with dack |
| mem_wr | output | 1 | Memory write strobe (I/O to memory) |
| mem_rd | output | 1 | Memory read strobe (memory to I/O) |
| tc | output | 1 | Terminal count |
| chan_masked | output | 1 | Channel mask state |
| cur_addr | output | 16 | Current address register |
| cur_count | output | 16 | Current count register |

## Verification
Terminal count and an explicit mask write can fall in the same cycle. The self-mask from terminal count and the software mask write then both try to update the mask bit. The bench provokes this by pulsing `mask_wr` with a clear value during the one-cycle acknowledge of a last, non-autoinit transfer. It judges the result by reading `chan_masked` afterwards (it must stay clear) and by confirming that a further request is accepted.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2,
        ST_HOLD = 2'd3
    } xfer_st_t;
endpackage

// File: rtl/dma_addr_map.sv
module dma_addr_map #(
    parameter int PAGE_W = 8,
    parameter int ADDR_W = 16,
    localparam int PHYS_W = PAGE_W + ADDR_W
) (
    input  logic              word_mode,
    input  logic [PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] cur,
    output logic [PHYS_W-1:0] phys
);
    logic [PHYS_W-1:0] byte_phys;
    logic [PHYS_W-1:0] word_phys;

    assign byte_phys = {page, cur};

    generate
        if (PAGE_W > 1) begin : g_wide_page
            // Word channel: page low bit replaced by the shifted counter.
            assign word_phys = {page[PAGE_W-1:1], cur, 1'b0};
        end else begin : g_narrow_page
            assign word_phys = {cur, 1'b0};
        end
    endgenerate

    assign phys = word_mode ? word_phys : byte_phys;
endmodule

// File: rtl/dma_step.sv
module dma_step #(
    parameter int ADDR_W = 16
) (
    input  logic              dec,
    input  logic              autoinit,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] cur_cnt,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] base_cnt,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [ADDR_W-1:0] nxt_cnt,
    output logic              last
);
    logic [ADDR_W-1:0] stepped;

    always_comb begin
        last    = (cur_cnt == '0);
        // Arithmetic stays inside ADDR_W bits: wrap, never carry to page.
        stepped = dec ? (cur_addr - ADDR_W'(1)) : (cur_addr + ADDR_W'(1));
        if (last && autoinit) begin
            nxt_addr = base_addr;
            nxt_cnt  = base_cnt;
        end else begin
            nxt_addr = stepped;
            nxt_cnt  = cur_cnt - ADDR_W'(1);
        end
    end
endmodule

// File: rtl/dma_hs_fsm.sv
module dma_hs_fsm
    import dma_eng_pkg::*;
(
    input  xfer_st_t st_q,
    input  logic     cascade,
    input  logic     masked,
    input  logic     dreq,
    input  logic     hlda,
    output xfer_st_t st_d
);
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (!cascade && dreq && !masked) st_d = ST_REQ;
            ST_REQ:  begin
                if (cascade)   st_d = ST_IDLE;
                else if (hlda) st_d = ST_XFER;
            end
            ST_XFER: st_d = ST_HOLD;
            ST_HOLD: if (!dreq) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_eng_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int ADDR_W = 16,
    localparam int PHYS_W = PAGE_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_word,
    input  logic              cfg_cascade,
    input  logic              cfg_autoinit,
    input  logic              cfg_dec,
    input  logic              cfg_to_mem,
    input  logic [PAGE_W-1:0] cfg_page,
    input  logic              prog_load,
    input  logic [ADDR_W-1:0] prog_base_addr,
    input  logic [ADDR_W-1:0] prog_base_cnt,
    input  logic              mask_wr,
    input  logic              mask_val,
    input  logic              dreq,
    input  logic              hlda,
    output logic              hrq,
    output logic              dack,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic              tc,
    output logic              chan_masked,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] cur_count
);
    typedef struct packed {
        xfer_st_t          st;
        logic              mask;
        logic [ADDR_W-1:0] base_a;
        logic [ADDR_W-1:0] base_c;
        logic [ADDR_W-1:0] cur_a;
        logic [ADDR_W-1:0] cur_c;
    } eng_t;

    eng_t eng_d, eng_q;

    xfer_st_t          st_nxt;
    logic [ADDR_W-1:0] step_a;
    logic [ADDR_W-1:0] step_c;
    logic              step_last;
    logic [PHYS_W-1:0] mapped;
    logic              xfer_now;

    dma_hs_fsm u_fsm (
        .st_q    (eng_q.st),
        .cascade (cfg_cascade),
        .masked  (eng_q.mask),
        .dreq    (dreq),
        .hlda    (hlda),
        .st_d    (st_nxt)
    );

    dma_step #(.ADDR_W(ADDR_W)) u_step (
        .dec       (cfg_dec),
        .autoinit  (cfg_autoinit),
        .cur_addr  (eng_q.cur_a),
        .cur_cnt   (eng_q.cur_c),
        .base_addr (eng_q.base_a),
        .base_cnt  (eng_q.base_c),
        .nxt_addr  (step_a),
        .nxt_cnt   (step_c),
        .last      (step_last)
    );

    dma_addr_map #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_map (
        .word_mode (cfg_word),
        .page      (cfg_page),
        .cur       (eng_q.cur_a),
        .phys      (mapped)
    );

    assign xfer_now = (eng_q.st == ST_XFER) && !cfg_cascade;

    always_comb begin
        eng_d    = eng_q;
        eng_d.st = st_nxt;
        if (xfer_now) begin
            eng_d.cur_a = step_a;
            eng_d.cur_c = step_c;
            if (step_last && !cfg_autoinit) eng_d.mask = 1'b1;
        end
        // Loading outranks the transfer step.
        if (prog_load) begin
            eng_d.base_a = prog_base_addr;
            eng_d.base_c = prog_base_cnt;
            eng_d.cur_a  = prog_base_addr;
            eng_d.cur_c  = prog_base_cnt;
        end
        // Software mask write outranks the terminal-count self-mask.
        if (mask_wr) eng_d.mask = mask_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q.st     <= ST_IDLE;
            eng_q.mask   <= 1'b1;
            eng_q.base_a <= '0;
            eng_q.base_c <= '0;
            eng_q.cur_a  <= '0;
            eng_q.cur_c  <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    always_comb begin
        if (cfg_cascade) begin
            hrq  = dreq && !eng_q.mask;
            dack = dreq && !eng_q.mask && hlda;
        end else begin
            hrq  = (eng_q.st == ST_REQ) || xfer_now;
            dack = xfer_now;
        end
    end

    assign phys_addr   = xfer_now ? mapped : '0;
    assign tc          = xfer_now && step_last;
    assign mem_wr      = xfer_now && cfg_to_mem;
    assign mem_rd      = xfer_now && !cfg_to_mem;
    assign chan_masked = eng_q.mask;
    assign cur_addr    = eng_q.cur_a;
    assign cur_count   = eng_q.cur_c;
endmodule

module dma_chan_engine_chk #(
    parameter int PAGE_W = 8,
    parameter int ADDR_W = 16,
    localparam int PHYS_W = PAGE_W + ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_word,
    input logic              cfg_cascade,
    input logic              cfg_autoinit,
    input logic              prog_load,
    input logic              mask_wr,
    input logic              hrq,
    input logic              dack,
    input logic              hlda,
    input logic [PHYS_W-1:0] phys_addr,
    input logic              tc,
    input logic              chan_masked,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [ADDR_W-1:0] cur_count
);
    a_r2_word_even: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && cfg_word && !cfg_cascade) |-> (phys_addr[0] == 1'b0));

    a_r4_tc_in_dack: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> dack);

    a_r4_count_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !cfg_autoinit && !prog_load) |=> (cur_count == '1));

    a_r7_self_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !cfg_autoinit && !mask_wr) |=> chan_masked);

    a_r8_dack_single: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && !cfg_cascade) |=> (!dack || cfg_cascade));

    a_r8_dack_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dack) && !cfg_cascade && $past(!cfg_cascade)) |-> $past(hrq && hlda));

    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_masked && !hrq && !cfg_cascade) |=> (!hrq || cfg_cascade));

    a_r10_cascade_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cascade && $past(cfg_cascade) && !$past(prog_load))
            |-> ($stable(cur_addr) && $stable(cur_count)));
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_word     (cfg_word),
    .cfg_cascade  (cfg_cascade),
    .cfg_autoinit (cfg_autoinit),
    .prog_load    (prog_load),
    .mask_wr      (mask_wr),
    .hrq          (hrq),
    .dack         (dack),
    .hlda         (hlda),
    .phys_addr    (phys_addr),
    .tc           (tc),
    .chan_masked  (chan_masked),
    .cur_addr     (cur_addr),
    .cur_count    (cur_count)
);

// File: tb/dma_chan_engine_tb.sv
`timescale 1ns/1ps
module dma_chan_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_word = 0, cfg_cascade = 0, cfg_autoinit = 0, cfg_dec = 0, cfg_to_mem = 0;
    logic [7:0]  cfg_page = '0;
    logic        prog_load = 0;
    logic [15:0] prog_base_addr = '0, prog_base_cnt = '0;
    logic        mask_wr = 0, mask_val = 0, dreq = 0, hlda = 0;
    logic        hrq, dack, mem_wr, mem_rd, tc, chan_masked;
    logic [23:0] phys_addr;
    logic [15:0] cur_addr, cur_count;

    always #2.5 clk = ~clk;

    dma_chan_engine u_dut (.*);

    int checks = 0;
    int fails  = 0;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural reference model: phase 0 idle, 1 requesting, 2 granted, 3 waiting for release
    int m_ph = 0;
    int m_mask = 1;
    int m_ba = 0, m_bc = 0, m_ca = 0, m_cc = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_mask = 1; m_ba = 0; m_bc = 0; m_ca = 0; m_cc = 0;
        end else begin
            int nph;
            bit grant;
            nph = m_ph;
            grant = (m_ph == 2) && !cfg_cascade;
            if (m_ph == 0 && !cfg_cascade && dreq && m_mask == 0) nph = 1;
            else if (m_ph == 1 && cfg_cascade) nph = 0;
            else if (m_ph == 1 && hlda) nph = 2;
            else if (m_ph == 2) nph = 3;
            else if (m_ph == 3 && !dreq) nph = 0;
            if (grant) begin
                if (m_cc == 0 && cfg_autoinit) begin
                    m_ca = m_ba; m_cc = m_bc;
                end else begin
                    if (m_cc == 0) m_mask = 1;
                    m_ca = (cfg_dec ? m_ca - 1 : m_ca + 1) & 'hFFFF;
                    m_cc = (m_cc - 1) & 'hFFFF;
                end
            end
            if (prog_load) begin
                m_ba = prog_base_addr; m_bc = prog_base_cnt;
                m_ca = prog_base_addr; m_cc = prog_base_cnt;
            end
            if (mask_wr) m_mask = mask_val;
            m_ph = nph;
        end
    end

    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            bit g;
            int e_hrq, e_dack, e_phys;
            g = (m_ph == 2) && !cfg_cascade;
            if (cfg_cascade) begin
                e_hrq  = (dreq && m_mask == 0);
                e_dack = (dreq && m_mask == 0 && hlda);
            end else begin
                e_hrq  = (m_ph == 1) || g;
                e_dack = g;
            end
            e_phys = !g ? 0 : cfg_word ? (((cfg_page & 'hFE) << 16) | (m_ca << 1))
                                       : ((cfg_page << 16) | m_ca);
            check("R8 model hrq", hrq, e_hrq);
            check("R8 model dack", dack, e_dack);
            check("R1 R2 model phys_addr", phys_addr, e_phys);
            check("R4 model tc", tc, g && m_cc == 0);
            check("R11 model mem_wr", mem_wr, g && cfg_to_mem);
            check("R11 model mem_rd", mem_rd, g && !cfg_to_mem);
            check("R7 model mask", chan_masked, m_mask);
            check("R5 model cur_addr", cur_addr, m_ca);
            check("R4 model cur_count", cur_count, m_cc);
        end
    end

    task automatic load(input int a, input int c);
        @(negedge clk);
        prog_base_addr = a[15:0]; prog_base_cnt = c[15:0]; prog_load = 1;
        @(negedge clk);
        prog_load = 0;
    endtask

    task automatic set_mask(input bit v);
        @(negedge clk);
        mask_wr = 1; mask_val = v;
        @(negedge clk);
        mask_wr = 0;
    endtask

    // One full handshake; returns values seen in the acknowledge cycle.
    task automatic xfer(output int ph, output bit t, output bit ak, input bit clash);
        @(negedge clk);
        dreq = 1;
        @(negedge clk);
        check("R8 hrq after dreq", hrq, 1);
        check("R8 no dack before hlda", dack, 0);
        hlda = 1;
        @(negedge clk);
        ak = dack; ph = phys_addr; t = tc;
        hlda = 0; dreq = 0;
        if (clash) begin mask_wr = 1; mask_val = 0; end
        @(negedge clk);
        mask_wr = 0;
        check("R8 dack one cycle", dack, 0);
        @(negedge clk);
    endtask

    initial begin
        int ph;
        bit t, ak;
        repeat (4) @(negedge clk);
        check("R13 reset hrq", hrq, 0);
        check("R13 reset dack", dack, 0);
        check("R13 reset tc", tc, 0);
        check("R13 reset mask", chan_masked, 1);
        check("R13 reset cur_addr", cur_addr, 0);
        check("R13 reset cur_count", cur_count, 0);
        rst_n = 1;

        // Masked after reset: request ignored (R9)
        @(negedge clk); dreq = 1;
        repeat (4) begin @(negedge clk); check("R9 masked hrq low", hrq, 0); end
        dreq = 0;

        // Byte channel, count 2 -> three transfers (R1 R4 R5 R7 R11 R12)
        cfg_page = 8'hA5; cfg_to_mem = 1;
        load('h1234, 2);
        @(negedge clk);
        check("R12 load cur_addr", cur_addr, 'h1234);
        check("R12 load cur_count", cur_count, 2);
        set_mask(0);
        xfer(ph, t, ak, 0);
        check("R1 byte phys 0", ph, 'hA51234); check("R4 tc early 0", t, 0); check("R8 dack seen", ak, 1);
        xfer(ph, t, ak, 0);
        check("R5 byte phys 1", ph, 'hA51235); check("R4 tc early 1", t, 0);
        xfer(ph, t, ak, 0);
        check("R1 byte phys 2", ph, 'hA51236); check("R4 tc on last", t, 1);
        check("R7 self mask", chan_masked, 1);
        check("R4 count wrapped", cur_count, 'hFFFF);
        check("R5 addr after three", cur_addr, 'h1237);
        @(negedge clk); dreq = 1;
        repeat (3) begin @(negedge clk); check("R9 masked after tc", hrq, 0); end
        dreq = 0;

        // Address wrap inside 16 bits (R3)
        cfg_page = 8'h3C; cfg_to_mem = 0;
        load('hFFFF, 1); set_mask(0);
        xfer(ph, t, ak, 0);
        check("R3 phys at top", ph, 'h3CFFFF);
        check("R11 mem_rd path", ak, 1);
        xfer(ph, t, ak, 0);
        check("R3 wrap keeps page", ph, 'h3C0000); check("R4 tc after two", t, 1);

        // Word channel, decrement, page bit0 ignored (R2 R5)
        cfg_word = 1; cfg_dec = 1; cfg_page = 8'h5B;
        load('h8001, 3); set_mask(0);
        xfer(ph, t, ak, 0);
        check("R2 word phys", ph, 'h5B0002);
        xfer(ph, t, ak, 0);
        check("R5 word dec phys", ph, 'h5B0000);
        check("R5 dec cur_addr", cur_addr, 'h7FFF);
        // Decrement wraps below zero (R3)
        load('h0000, 1); set_mask(0);
        xfer(ph, t, ak, 0);
        check("R2 word phys zero", ph, 'h5A0000);
        check("R3 dec wrap", cur_addr, 'hFFFF);
        cfg_word = 0; cfg_dec = 0;

        // Autoinit with count 0 (R6)
        cfg_autoinit = 1; cfg_page = 8'h01;
        load('h0100, 0); set_mask(0);
        xfer(ph, t, ak, 0);
        check("R6 tc single", t, 1);
        check("R6 reload addr", cur_addr, 'h0100);
        check("R6 reload count", cur_count, 0);
        check("R6 mask kept", chan_masked, 0);
        xfer(ph, t, ak, 0);
        check("R6 second run phys", ph, 'h010100); check("R6 second tc", t, 1);
        cfg_autoinit = 0;

        // Request held high: one transfer only until released (R8)
        load('h0040, 5);
        @(negedge clk); dreq = 1;
        @(negedge clk); hlda = 1;
        @(negedge clk); check("R8 held dack", dack, 1); hlda = 1;
        repeat (4) begin @(negedge clk); check("R8 held no rerequest", hrq, 0); end
        hlda = 0; dreq = 0;
        @(negedge clk); @(negedge clk);
        check("R8 one step only", cur_count, 4);

        // Mask write collides with terminal count (R7)
        load('h0200, 0);
        xfer(ph, t, ak, 1);
        check("R7 clash tc", t, 1);
        check("R7 mask write wins", chan_masked, 0);
        xfer(ph, t, ak, 0);
        check("R7 still accepts", ak, 1);

        // Cascade pass-through (R10)
        load('h0300, 7); set_mask(0);
        cfg_cascade = 1;
        @(negedge clk); dreq = 1; #1;
        check("R10 cascade hrq", hrq, 1);
        check("R10 cascade no dack", dack, 0);
        @(negedge clk); hlda = 1; #1;
        check("R10 cascade dack", dack, 1);
        check("R10 cascade tc low", tc, 0);
        repeat (3) @(negedge clk);
        dreq = 0; hlda = 0;
        @(negedge clk);
        check("R10 cascade addr frozen", cur_addr, 'h0300);
        check("R10 cascade count frozen", cur_count, 7);
        set_mask(1);
        @(negedge clk); dreq = 1; #1;
        check("R10 cascade masked", hrq, 0);
        dreq = 0; cfg_cascade = 0;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule